// File: doc/BRIEF.md
# GPIO Output Blink Generator

This block overlays a slow square wave onto a bank of 32 general-purpose output pins. A read/write blink-enable register on a simple register bus selects which pins blink. When a pin is configured as an output and its enable is set, the pin follows a shared phase signal that toggles about once per second. In every other case the pin drives the value from its level register, which this block never modifies. The level and direction registers live elsewhere and reach the block as plain inputs.

The phase comes from a prescaler that divides the system clock. It toggles every `HALF_CYCLES` clocks, so each half-period lasts that many cycles. Only five enable positions are implemented. Three of them (28, 27, 25) sit in the resume domain, which is cleared only by the resume reset. The other two (19, 18) sit in the core domain, which is cleared by the core reset. Bit 18 comes out of core reset already set, so that pin blinks as a boot-failure indicator until firmware clears the bit.

Top module: `gpio_blink_top`

## Requirements
- R1: The blink-enable register is written when `bus_wr` is high and `bus_addr` equals `BLINK_OFFSET` (default 8'h18). `bus_rdata` shows the register whenever `bus_addr` equals `BLINK_OFFSET` and is zero at any other address. After both resets the register reads 32'h0004_0000.
- R2: Only bits 28, 27, 25, 19 and 18 are implemented. All other bits read zero and ignore writes, so writing all ones reads back 32'h1A0C_0000.
- R3: A single phase signal is shared by all pins. It is low after core reset and toggles every `HALF_CYCLES` clocks.
- R4: A pin whose direction bit is 1 (output) and whose enable bit is set drives the phase value, registered with one cycle of latency.
- R5: A pin whose direction bit is 0 (input) drives its level bit one cycle later, whatever its enable bit holds.
- R6: When an enable bit is cleared, the pin drives its level bit on the clock after the register update.
- R7: Core reset (synchronous, active low) sets bits 19:18 to 2'b01, forces all pins to 0 and restarts the phase low. It leaves bits 28, 27 and 25 unchanged.
- R8: Resume reset (synchronous, active low) clears bits 28, 27 and 25 and leaves bits 19:18 unchanged.
- R9: With no software write after core reset, output-configured pin 18 blinks while pin 19 follows its level bit.
- R10: Pins at reserved positions never blink: they drive their level bit even when configured as outputs and written with ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also drives the prescaler |
| core_rst_n | input | 1 | Synchronous active-low core reset |
| resume_rst_n | input | 1 | Synchronous active-low resume-domain reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| gpio_dir_out | input | 32 | Per-pin direction, 1 = output |
| gpio_level | input | 32 | Per-pin level register value |
| gpio_pin | output | 32 | Value driven to each pin |

## Verification
The hardest case to reach is a domain split: one reset asserted while the other domain holds non-default bits. The stimulus first writes all ones and then pulses only the core reset, and later does the same with only the resume reset, so each domain's bits are shown to survive the other domain's reset. The phase is made observable by shrinking `HALF_CYCLES` to six. Pin 18 then blinks straight out of reset, and the spacing of its edges gives the half-period. A behavioural model compares every pin and the read data on every clock.

// File: rtl/gpio_blink_pkg.sv
// Shared constants for the blink generator: register width and the
// bit maps of the two reset domains.
package gpio_blink_pkg;
    localparam int unsigned REG_W = 32;
    // enable bits held in the resume domain (28, 27, 25)
    localparam logic [REG_W-1:0] RESUME_MASK  = 32'h1A00_0000;
    // enable bits held in the core domain (19, 18)
    localparam logic [REG_W-1:0] CORE_MASK    = 32'h000C_0000;
    // core-domain value after reset: bit 18 set as boot-failure indicator
    localparam logic [REG_W-1:0] CORE_DEFAULT = 32'h0004_0000;
endpackage

// File: rtl/gpio_blink_prescaler.sv
// Divides the system clock into a square-wave phase that toggles every
// HALF_CYCLES clocks. Assumes HALF_CYCLES >= 2. Reset is synchronous,
// active low, and leaves the phase low.
module gpio_blink_prescaler #(
    parameter int unsigned HALF_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int unsigned CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;

    // count one half-period, then wrap and flip the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign phase = phase_q;

    AST_PHASE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (phase_q != $past(phase_q))) |-> ($past(cnt_q) == LAST)); // R3
endmodule

// File: rtl/gpio_blink_regs.sv
// Blink-enable register split over two reset domains. Reserved bits
// always read zero. Read data is combinational from the address.
module gpio_blink_regs
    import gpio_blink_pkg::*;
#(
    parameter int unsigned      ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFFSET = 8'h18
) (
    input  logic              clk,
    input  logic              core_rst_n,
    input  logic              resume_rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  enable,
    output logic [REG_W-1:0]  rdata
);
    logic             hit;
    logic [REG_W-1:0] core_q;
    logic [REG_W-1:0] resume_q;

    // decode the register offset
    assign hit = (addr == OFFSET);

    // core-domain bits: reset to the boot-indicator default
    always_ff @(posedge clk) begin
        if (!core_rst_n)
            core_q <= CORE_DEFAULT;
        else if (wr && hit)
            core_q <= wdata & CORE_MASK;
    end

    // resume-domain bits: cleared only by the resume reset
    always_ff @(posedge clk) begin
        if (!resume_rst_n)
            resume_q <= '0;
        else if (wr && hit)
            resume_q <= wdata & RESUME_MASK;
    end

    // merge the domains and drive read data
    always_comb begin
        enable = core_q | resume_q;
        rdata  = hit ? enable : '0;
    end

    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!core_rst_n)
        (rdata & ~(CORE_MASK | RESUME_MASK)) == '0); // R2
    AST_CORE_DEFAULT: assert property (@(posedge clk) disable iff (!core_rst_n)
        $past(!core_rst_n) |-> (enable[18] && !enable[19])); // R7
    AST_RESUME_KEEP: assert property (@(posedge clk) disable iff (!resume_rst_n)
        ($past(resume_rst_n) && !core_rst_n && !(wr && hit))
        |=> ((enable & RESUME_MASK) == $past(enable & RESUME_MASK))); // R7
endmodule

// File: rtl/gpio_blink_drive.sv
// Per-pin output stage: a pin drives the phase when it is an output and
// its enable is set, otherwise it drives its level bit. Registered, with
// a synchronous active-low reset to zero.
module gpio_blink_drive #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase,
    input  logic [WIDTH-1:0] enable,
    input  logic [WIDTH-1:0] dir_out,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] pin
);
    logic [WIDTH-1:0] pin_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // select the phase or the level bit for this pin
        always_ff @(posedge clk) begin
            if (!rst_n)
                pin_q[i] <= 1'b0;
            else
                pin_q[i] <= (dir_out[i] && enable[i]) ? phase : level[i];
        end
    end

    assign pin = pin_q;

    AST_INPUT_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((pin_q ^ $past(level)) & ~$past(dir_out)) == '0)); // R5
    AST_BLINK_TRACKS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((pin_q ^ {WIDTH{$past(phase)}}) & $past(dir_out & enable)) == '0)); // R4
endmodule

// File: rtl/gpio_blink_top.sv
// Top level of the blink generator: register, shared prescaler and the
// per-pin drive stage. The level and direction registers are external.
module gpio_blink_top
    import gpio_blink_pkg::*;
#(
    parameter int unsigned       ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] BLINK_OFFSET = 8'h18,
    parameter int unsigned       HALF_CYCLES  = 50_000_000
) (
    input  logic              clk,
    input  logic              core_rst_n,
    input  logic              resume_rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [REG_W-1:0]  gpio_dir_out,
    input  logic [REG_W-1:0]  gpio_level,
    output logic [REG_W-1:0]  gpio_pin
);
    logic [REG_W-1:0] enable;
    logic             phase;

    gpio_blink_regs #(.ADDR_W(ADDR_W), .OFFSET(BLINK_OFFSET)) u_regs (
        .clk          (clk),
        .core_rst_n   (core_rst_n),
        .resume_rst_n (resume_rst_n),
        .wr           (bus_wr),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .enable       (enable),
        .rdata        (bus_rdata)
    );

    gpio_blink_prescaler #(.HALF_CYCLES(HALF_CYCLES)) u_presc (
        .clk   (clk),
        .rst_n (core_rst_n),
        .phase (phase)
    );

    gpio_blink_drive #(.WIDTH(REG_W)) u_drive (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .phase   (phase),
        .enable  (enable),
        .dir_out (gpio_dir_out),
        .level   (gpio_level),
        .pin     (gpio_pin)
    );

    AST_RESERVED_NO_BLINK: assert property (@(posedge clk) disable iff (!core_rst_n)
        $past(core_rst_n) |->
        (((gpio_pin ^ $past(gpio_level)) & ~(CORE_MASK | RESUME_MASK)) == '0)); // R10
endmodule

// File: tb/tb_gpio_blink_top.sv
module tb_gpio_blink_top;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        core_rst_n = 1'b0;
    logic        resume_rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h18;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] gpio_dir_out = '0;
    logic [31:0] gpio_level = '0;
    logic [31:0] gpio_pin;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit model_ok = 1'b0;

    always #5 clk = ~clk;

    gpio_blink_top #(.ADDR_W(8), .BLINK_OFFSET(8'h18), .HALF_CYCLES(HALF)) dut (
        .clk(clk), .core_rst_n(core_rst_n), .resume_rst_n(resume_rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .gpio_dir_out(gpio_dir_out),
        .gpio_level(gpio_level), .gpio_pin(gpio_pin)
    );

    // behavioural reference model
    logic [31:0] m_core, m_res, m_pin;
    int          m_cnt;
    bit          m_phase;

    always @(posedge clk) begin
        logic [31:0] en;
        en = m_core | m_res;
        if (!core_rst_n) begin
            m_cnt <= 0; m_phase <= 1'b0; m_pin <= '0; m_core <= 32'h0004_0000;
        end else begin
            if (m_cnt == HALF - 1) begin m_cnt <= 0; m_phase <= !m_phase; end
            else m_cnt <= m_cnt + 1;
            for (int b = 0; b < 32; b++)
                m_pin[b] <= (gpio_dir_out[b] && en[b]) ? m_phase : gpio_level[b];
            if (bus_wr && bus_addr == 8'h18) m_core <= bus_wdata & 32'h000C_0000;
        end
        if (!resume_rst_n) m_res <= '0;
        else if (bus_wr && bus_addr == 8'h18) m_res <= bus_wdata & 32'h1A00_0000;
        if (core_rst_n && resume_rst_n) model_ok <= 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(posedge clk) begin
        #2;
        if (model_ok && !done) begin
            chk("R4 R5 pin model", gpio_pin, m_pin);
            chk("R1 read model", bus_rdata, (bus_addr == 8'h18) ? (m_core | m_res) : 32'h0);
        end
    end

    task automatic wr_reg(input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        report();
    end

    initial begin
        int last, gap, t;
        repeat (3) @(negedge clk);
        core_rst_n = 1'b1; resume_rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset value", bus_rdata, 32'h0004_0000);
        chk("R7 pins zero after reset", gpio_pin, 32'h0);

        // R9 and R3: pin 18 blinks from reset, edges spaced HALF cycles
        gpio_dir_out = 32'hFFFF_FFFF; gpio_level = '0;
        last = -1; gap = 0; t = 0;
        for (int c = 0; c < 4 * HALF; c++) begin
            logic p;
            p = gpio_pin[18];
            @(negedge clk); t++;
            if (gpio_pin[18] != p) begin
                if (last >= 0) gap = t - last;
                last = t;
            end
            if (gpio_pin[19] !== 1'b0) chk("R9 pin 19 idle", {31'b0, gpio_pin[19]}, 32'h0);
        end
        chk("R9 pin 18 toggled", {31'b0, last >= 0}, 32'h1);
        chk("R3 half period", gap, HALF);

        // R2: write all ones, only implemented bits stick
        wr_reg(32'hFFFF_FFFF);
        chk("R2 implemented bits", bus_rdata, 32'h1A0C_0000);
        bus_addr = 8'h1C; #1;
        chk("R1 other address reads zero", bus_rdata, 32'h0);
        bus_addr = 8'h18;

        // R10: reserved positions drive level while outputs blink
        gpio_level = 32'h0000_0000;
        for (int c = 0; c < 2 * HALF; c++) begin
            @(negedge clk);
            chk("R10 reserved pins follow level", gpio_pin & ~32'h1A0C_0000, 32'h0);
        end

        // R5: inputs follow level even with enables set
        gpio_dir_out = '0; gpio_level = 32'hA5A5_5A5A;
        @(negedge clk);
        chk("R5 input follows level", gpio_pin, 32'hA5A5_5A5A);

        // R6: clearing enables returns outputs to level
        gpio_dir_out = 32'hFFFF_FFFF; gpio_level = 32'hFFFF_FFFF;
        wait (dut.gpio_pin[18] == 1'b0);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = 32'h0;
        @(negedge clk); bus_wr = 1'b0;
        @(negedge clk);
        chk("R6 level after disable", gpio_pin, 32'hFFFF_FFFF);

        // R7: core reset alone keeps resume bits
        wr_reg(32'hFFFF_FFFF);
        core_rst_n = 1'b0; @(negedge clk); core_rst_n = 1'b1;
        chk("R7 core reset keeps resume bits", bus_rdata, 32'h1A04_0000);

        // R8: resume reset alone keeps core bits
        wr_reg(32'hFFFF_FFFF);
        resume_rst_n = 1'b0; @(negedge clk); resume_rst_n = 1'b1;
        chk("R8 resume reset keeps core bits", bus_rdata, 32'h000C_0000);

        // R4: enabled output in resume domain blinks
        gpio_level = '0;
        wr_reg(32'h0200_0000);
        t = 0;
        for (int c = 0; c < 3 * HALF; c++) begin
            @(negedge clk);
            if (gpio_pin[25]) t++;
        end
        chk("R4 pin 25 blinks", {31'b0, (t > 0) && (t < 3 * HALF)}, 32'h1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        report();
    end
endmodule